// File: doc/BRIEF.md
# Decoder Host Control Register Block

This block sits between a host processor and a streaming audio decoder engine. The host reaches it through a single-master, word-indexed register port with Wishbone-style handshaking. Through that port the host programs four buffer base addresses, sets an interrupt mask and selects the byte order. It can also read the header word of the most recent frame and a fixed version identifier. The block turns host commands into engine controls: a soft-reset pulse, a start pulse, a hold level and one resume pulse for each stall reason.

The engine stalls for two reasons. It stalls when it has used up its input area, and it stalls when it has finished writing an output frame. Each stall reason has its own sticky flag. The engine sets the flag, and the host clears it by writing 1 to it. That write is also what releases the stall. While a flag is pending, the host can reprogram the address of the buffer concerned. The engine then continues into a fresh buffer, which gives double buffering.

The interrupt output is the OR of each pending flag gated by its mask bit.

Top module: `dec_host_regs`

## Requirements
- R1: After reset, every register reads zero except the VERSION word at index 15. VERSION reads the version identifier in bits 15:0 and the reset value of the byte-order bit in bit 31 (default 0x0000_0103). Also after reset, irq_o, eng_hold_o and all engine pulses are low.
- R2: Every access is acknowledged. The acknowledge is a single-cycle wb_ack_o in the cycle after the strobe is first seen. Read data is valid on wb_dat_o while wb_ack_o is high.
- R3: The address registers are read start (index 2), read end (3), write start (4) and scratch start (5). Each stores the written word with bits 1:0 forced to zero, reads it back, and drives it on its output port.
- R4: Indexes 7 to 14 read as zero. Writes to them change no register, and the access is still acknowledged.
- R5: Writing STATUS (index 0) with bit 1 set while the engine is idle does three things. It sets the busy bit (STATUS bit 2) and gives a one-cycle eng_start_o pulse, and the engine runs from the addresses programmed at that moment. While the engine is busy, the same write produces no pulse.
- R6: Writing STATUS with bit 0 set clears busy, both flags and HEADER, and gives a one-cycle eng_reset_o pulse. It keeps the address registers, the mask and the byte-order bit. It wins over bit 1 in the same write.
- R7: ev_frame_done_i while busy sets WriteReady (STATUS bit 9) and raises eng_hold_o. Writing 1 to bit 9 clears the flag and gives a one-cycle eng_wr_resume_o pulse. Writing 0 to bit 9 has no effect.
- R8: ev_input_empty_i while busy sets ReadEmpty (STATUS bit 8) and raises eng_hold_o. Writing 1 to bit 8 clears the flag and gives a one-cycle eng_rd_resume_o pulse.
- R9: An engine event in the same cycle as the host's write-1 to the same flag leaves the flag set and gives no resume pulse.
- R10: While a flag is pending, the address registers remain writable, and their new values appear on the outputs before the resume.
- R11: irq_o is high when ReadEmpty is set together with INTMASK bit 8, or when WriteReady is set together with INTMASK bit 9. The mask does not affect the flags.
- R12: HEADER (index 6) loads hdr_data_i on hdr_valid_i while busy. Host writes to HEADER are ignored.
- R13: VERSION bit 31 is writable and drives little_endian_o. VERSION bits 15:0 are read-only.
- R14: Engine events and header strobes arriving while idle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 4 | Word index |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Acknowledge |
| irq_o | output | 1 | Interrupt |
| ev_input_empty_i | input | 1 | Engine ran out of input |
| ev_frame_done_i | input | 1 | Engine finished an output frame |
| hdr_valid_i | input | 1 | Frame header strobe |
| hdr_data_i | input | 32 | Frame header word |
| eng_start_o | output | 1 | Start pulse |
| eng_reset_o | output | 1 | Soft reset pulse |
| eng_hold_o | output | 1 | Engine must stall |
| eng_rd_resume_o | output | 1 | Input stall released |
| eng_wr_resume_o | output | 1 | Output stall released |
| rd_start_o | output | 32 | Input area start |
| rd_end_o | output | 32 | Input area end |
| wr_start_o | output | 32 | Output buffer start |
| scratch_o | output | 32 | Scratch area start |
| little_endian_o | output | 1 | Byte order select |

## Verification
The bench drives a flag-set event in the same cycle as the host clear. A design that lets the clear win would lose a stall and resume the engine on a frame that nobody serviced. Writes of 0 to the flags are checked as well: a design that decodes the write as plain assignment would release the engine by accident. Soft reset is issued together with start while a flag is pending. A wrong priority would leave the engine running, or would wipe the programmed addresses. Events while idle, unmapped indexes, and writes to HEADER and to the version field are all probed at the ports, because a careless decoder would let them alter state.

// File: rtl/dec_host_pkg.sv
package dec_host_pkg;
  // word indexes
  localparam int unsigned REG_STATUS   = 0;
  localparam int unsigned REG_INTMASK  = 1;
  localparam int unsigned REG_ADDR_LO  = 2;
  localparam int unsigned NUM_ADDR     = 4;
  localparam int unsigned REG_HEADER   = 6;
  localparam int unsigned REG_VERSION  = 15;
  // STATUS bit positions
  localparam int unsigned ST_RESET     = 0;
  localparam int unsigned ST_START     = 1;
  localparam int unsigned ST_BUSY      = 2;
  localparam int unsigned ST_RD_EMPTY  = 8;
  localparam int unsigned ST_WR_READY  = 9;
  // address alignment
  localparam int unsigned ADDR_ALIGN   = 2;

  typedef struct packed {
    logic wr_ready;
    logic rd_empty;
  } flags_t;
endpackage

// File: rtl/dec_bus_if.sv
module dec_bus_if #(
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cyc_i,
  input  logic          stb_i,
  input  logic          we_i,
  input  logic [AW-1:0] adr_i,
  output logic          ack_o,
  output logic          wr_en_o,
  output logic          rd_en_o,
  output logic [AW-1:0] idx_o
);
  logic access;

  // one access per strobe; the cycle carrying ack is not a new access
  assign access  = cyc_i & stb_i & ~ack_o;
  assign wr_en_o = access & we_i;
  assign rd_en_o = access & ~we_i;
  assign idx_o   = adr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_o <= 1'b0;
    else         ack_o <= access;
  end
endmodule

// File: rtl/dec_addr_regs.sv
module dec_addr_regs #(
  parameter int unsigned AW        = 4,
  parameter int unsigned DW        = 32,
  parameter int unsigned NUM       = 4,
  parameter int unsigned FIRST_IDX = 2,
  parameter int unsigned ALIGN     = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [AW-1:0]            idx_i,
  input  logic [DW-1:ALIGN]        wdata_i,
  output logic [NUM-1:0][DW-1:0]   regs_o
);
  for (genvar g = 0; g < NUM; g++) begin : g_reg
    localparam logic [AW-1:0] MY_IDX = AW'(FIRST_IDX + g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          regs_o[g] <= '0;
      else if (wr_en_i && idx_i == MY_IDX)  regs_o[g] <= {wdata_i, {ALIGN{1'b0}}};
    end
  end
endmodule

// File: rtl/dec_flow_ctrl.sv
module dec_flow_ctrl
  import dec_host_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reset_req_i,
  input  logic          start_req_i,
  input  flags_t        clr_req_i,
  input  logic          ev_input_empty_i,
  input  logic          ev_frame_done_i,
  input  logic          hdr_valid_i,
  input  logic [DW-1:0] hdr_data_i,
  output logic          busy_o,
  output flags_t        flags_o,
  output logic [DW-1:0] header_o,
  output logic          eng_start_o,
  output logic          eng_reset_o,
  output flags_t        resume_o
);
  flags_t set_ev, clr_ok;

  assign set_ev.rd_empty = busy_o & ev_input_empty_i;
  assign set_ev.wr_ready = busy_o & ev_frame_done_i;
  assign clr_ok          = clr_req_i & flags_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o      <= 1'b0;
      flags_o     <= '0;
      header_o    <= '0;
      eng_start_o <= 1'b0;
      eng_reset_o <= 1'b0;
      resume_o    <= '0;
    end else if (reset_req_i) begin
      busy_o      <= 1'b0;
      flags_o     <= '0;
      header_o    <= '0;
      eng_start_o <= 1'b0;
      eng_reset_o <= 1'b1;
      resume_o    <= '0;
    end else begin
      eng_reset_o <= 1'b0;
      eng_start_o <= start_req_i & ~busy_o;
      if (start_req_i) busy_o <= 1'b1;
      if (hdr_valid_i && busy_o) header_o <= hdr_data_i;
      // set beats clear
      flags_o  <= set_ev | (flags_o & ~clr_ok);
      resume_o <= clr_ok & ~set_ev;
    end
  end
endmodule

// File: rtl/dec_host_regs.sv
module dec_host_regs
  import dec_host_pkg::*;
#(
  parameter int unsigned AW         = 4,
  parameter int unsigned DW         = 32,
  parameter logic [15:0] VERSION_ID = 16'h0103,
  parameter logic        LE_RESET   = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wb_cyc_i,
  input  logic          wb_stb_i,
  input  logic          wb_we_i,
  input  logic [AW-1:0] wb_adr_i,
  input  logic [DW-1:0] wb_dat_i,
  output logic [DW-1:0] wb_dat_o,
  output logic          wb_ack_o,
  output logic          irq_o,
  input  logic          ev_input_empty_i,
  input  logic          ev_frame_done_i,
  input  logic          hdr_valid_i,
  input  logic [DW-1:0] hdr_data_i,
  output logic          eng_start_o,
  output logic          eng_reset_o,
  output logic          eng_hold_o,
  output logic          eng_rd_resume_o,
  output logic          eng_wr_resume_o,
  output logic [DW-1:0] rd_start_o,
  output logic [DW-1:0] rd_end_o,
  output logic [DW-1:0] wr_start_o,
  output logic [DW-1:0] scratch_o,
  output logic          little_endian_o
);
  localparam int unsigned   LE_BIT      = DW - 1;
  localparam logic [AW-1:0] IDX_STATUS  = AW'(REG_STATUS);
  localparam logic [AW-1:0] IDX_INTMASK = AW'(REG_INTMASK);
  localparam logic [AW-1:0] IDX_HEADER  = AW'(REG_HEADER);
  localparam logic [AW-1:0] IDX_VERSION = AW'(REG_VERSION);
  localparam logic [AW-1:0] IDX_A0      = AW'(REG_ADDR_LO);
  localparam logic [AW-1:0] IDX_A1      = AW'(REG_ADDR_LO + 1);
  localparam logic [AW-1:0] IDX_A2      = AW'(REG_ADDR_LO + 2);
  localparam logic [AW-1:0] IDX_A3      = AW'(REG_ADDR_LO + 3);

  logic                    wr_en, rd_en;
  logic [AW-1:0]           idx;
  logic [NUM_ADDR-1:0][DW-1:0] addr_q;
  logic                    busy;
  flags_t                  flags, mask_q, clr_req, resume;
  logic [DW-1:0]           header_q, rdata;
  logic                    le_q, st_wr;
  logic                    rd_flag, wr_flag;

  dec_bus_if #(.AW(AW)) i_bus (
    .clk_i, .rst_ni,
    .cyc_i(wb_cyc_i), .stb_i(wb_stb_i), .we_i(wb_we_i), .adr_i(wb_adr_i),
    .ack_o(wb_ack_o), .wr_en_o(wr_en), .rd_en_o(rd_en), .idx_o(idx)
  );

  dec_addr_regs #(
    .AW(AW), .DW(DW), .NUM(NUM_ADDR), .FIRST_IDX(REG_ADDR_LO), .ALIGN(ADDR_ALIGN)
  ) i_addr (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .idx_i(idx), .wdata_i(wb_dat_i[DW-1:ADDR_ALIGN]),
    .regs_o(addr_q)
  );

  assign st_wr            = wr_en && idx == IDX_STATUS;
  assign clr_req.rd_empty = st_wr & wb_dat_i[ST_RD_EMPTY];
  assign clr_req.wr_ready = st_wr & wb_dat_i[ST_WR_READY];

  dec_flow_ctrl #(.DW(DW)) i_flow (
    .clk_i, .rst_ni,
    .reset_req_i(st_wr & wb_dat_i[ST_RESET]),
    .start_req_i(st_wr & wb_dat_i[ST_START]),
    .clr_req_i(clr_req),
    .ev_input_empty_i, .ev_frame_done_i, .hdr_valid_i, .hdr_data_i,
    .busy_o(busy), .flags_o(flags), .header_o(header_q),
    .eng_start_o, .eng_reset_o, .resume_o(resume)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      le_q   <= LE_RESET;
    end else if (wr_en) begin
      if (idx == IDX_INTMASK) begin
        mask_q.rd_empty <= wb_dat_i[ST_RD_EMPTY];
        mask_q.wr_ready <= wb_dat_i[ST_WR_READY];
      end
      if (idx == IDX_VERSION) le_q <= wb_dat_i[LE_BIT];
    end
  end

  always_comb begin
    rdata = '0;
    unique case (idx)
      IDX_STATUS: begin
        rdata[ST_BUSY]     = busy;
        rdata[ST_RD_EMPTY] = flags.rd_empty;
        rdata[ST_WR_READY] = flags.wr_ready;
      end
      IDX_INTMASK: begin
        rdata[ST_RD_EMPTY] = mask_q.rd_empty;
        rdata[ST_WR_READY] = mask_q.wr_ready;
      end
      IDX_A0:      rdata = addr_q[0];
      IDX_A1:      rdata = addr_q[1];
      IDX_A2:      rdata = addr_q[2];
      IDX_A3:      rdata = addr_q[3];
      IDX_HEADER:  rdata = header_q;
      IDX_VERSION: begin
        rdata[15:0]   = VERSION_ID;
        rdata[LE_BIT] = le_q;
      end
      default:     rdata = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    wb_dat_o <= '0;
    else if (rd_en) wb_dat_o <= rdata;
    else if (wr_en) wb_dat_o <= '0;
  end

  assign rd_flag         = flags.rd_empty;
  assign wr_flag         = flags.wr_ready;
  assign irq_o           = |(flags & mask_q);
  assign eng_hold_o      = rd_flag | wr_flag;
  assign eng_rd_resume_o = resume.rd_empty;
  assign eng_wr_resume_o = resume.wr_ready;
  assign rd_start_o      = addr_q[0];
  assign rd_end_o        = addr_q[1];
  assign wr_start_o      = addr_q[2];
  assign scratch_o       = addr_q[3];
  assign little_endian_o = le_q;
endmodule

// File: rtl/dec_host_chk.sv
module dec_host_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wb_cyc_i,
  input logic       wb_stb_i,
  input logic       wb_ack_o,
  input logic       irq_o,
  input logic       ev_input_empty_i,
  input logic       ev_frame_done_i,
  input logic       eng_start_o,
  input logic       eng_reset_o,
  input logic       eng_hold_o,
  input logic       eng_rd_resume_o,
  input logic       eng_wr_resume_o,
  input logic [1:0] rd_start_lo,
  input logic [1:0] wr_start_lo,
  input logic       busy_i,
  input logic       rd_flag_i,
  input logic       wr_flag_i
);
  // R2
  ack_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_cyc_i && wb_stb_i && !wb_ack_o) |=> wb_ack_o);
  // R2
  ack_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_ack_o |=> !wb_ack_o);
  // R3
  addr_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_start_lo == 2'b00 && wr_start_lo == 2'b00);
  // R5
  start_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> busy_i && !$past(busy_i));
  // R7
  wr_resume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_wr_resume_o |-> !wr_flag_i && $past(wr_flag_i));
  // R8
  rd_resume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_rd_resume_o |-> !rd_flag_i && $past(rd_flag_i));
  // R9
  wr_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && ev_frame_done_i) |=> (wr_flag_i || eng_reset_o));
  // R9
  rd_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && ev_input_empty_i) |=> (rd_flag_i || eng_reset_o));
  // R14
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !rd_flag_i && !wr_flag_i && !irq_o);
  // R11
  irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> eng_hold_o);
  // R6
  reset_idles_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_reset_o |-> !busy_i && !eng_hold_o);
endmodule

bind dec_host_regs dec_host_chk i_dec_host_chk (
  .clk_i, .rst_ni, .wb_cyc_i, .wb_stb_i, .wb_ack_o, .irq_o,
  .ev_input_empty_i, .ev_frame_done_i,
  .eng_start_o, .eng_reset_o, .eng_hold_o, .eng_rd_resume_o, .eng_wr_resume_o,
  .rd_start_lo(rd_start_o[1:0]), .wr_start_lo(wr_start_o[1:0]),
  .busy_i(busy), .rd_flag_i(rd_flag), .wr_flag_i(wr_flag)
);

// File: tb/test_dec_host_regs.sv
module test_dec_host_regs;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cyc = 0, stb = 0, we = 0;
  logic [3:0]  adr = '0;
  logic [31:0] wdat = '0, rdat, hdr_d = '0;
  logic        ev_e = 0, ev_d = 0, hdr_v = 0;
  logic        ack, irq, p_start, p_reset, hold, p_rres, p_wres, le;
  logic [31:0] rd_s, rd_e, wr_s, scr;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  // captured in the acknowledge cycle of the last access
  logic c_ack, c_start, c_reset, c_rres, c_wres;
  logic [31:0] c_dat;

  always #10 clk = ~clk;

  dec_host_regs i_dec_host_regs (
    .clk_i(clk), .rst_ni(rst_n),
    .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_adr_i(adr),
    .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack), .irq_o(irq),
    .ev_input_empty_i(ev_e), .ev_frame_done_i(ev_d),
    .hdr_valid_i(hdr_v), .hdr_data_i(hdr_d),
    .eng_start_o(p_start), .eng_reset_o(p_reset), .eng_hold_o(hold),
    .eng_rd_resume_o(p_rres), .eng_wr_resume_o(p_wres),
    .rd_start_o(rd_s), .rd_end_o(rd_e), .wr_start_o(wr_s), .scratch_o(scr),
    .little_endian_o(le)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [3:0] a, input logic [31:0] d,
                     input logic e_empty, input logic e_done);
    @(negedge clk);
    cyc = 1; stb = 1; we = w; adr = a; wdat = d; ev_e = e_empty; ev_d = e_done;
    @(posedge clk);
    @(negedge clk);
    c_ack = ack; c_dat = rdat; c_start = p_start; c_reset = p_reset;
    c_rres = p_rres; c_wres = p_wres;
    cyc = 0; stb = 0; we = 0; ev_e = 0; ev_d = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    bus(1'b0, a, 32'h0, 1'b0, 1'b0);
    check(req, {31'b0, c_ack}, 32'h1);
    check(req, c_dat, exp);
  endtask

  task automatic engine(input logic e_empty, input logic e_done);
    @(negedge clk); ev_e = e_empty; ev_d = e_done;
    @(negedge clk); ev_e = 0; ev_d = 0;
  endtask

  task automatic header(input logic [31:0] h);
    @(negedge clk); hdr_v = 1; hdr_d = h;
    @(negedge clk); hdr_v = 0;
  endtask

  task automatic t_reset_state();
    rd_chk("R1 status", 4'd0, 32'h0);
    rd_chk("R1 mask", 4'd1, 32'h0);
    for (int i = 2; i <= 6; i++) rd_chk("R1 reg", 4'(i), 32'h0);
    rd_chk("R1 version", 4'd15, 32'h0000_0103);
    check("R1 irq/hold/pulses", {27'b0, irq, hold, p_start, p_reset, p_wres}, 32'h0);
  endtask

  task automatic t_addr();
    wr(4'd2, 32'h1000_0003);
    check("R2 write ack", {31'b0, c_ack}, 32'h1);
    wr(4'd3, 32'h1000_7FFE);
    wr(4'd4, 32'h2000_0001);
    wr(4'd5, 32'h3000_0102);
    rd_chk("R3 rd_start", 4'd2, 32'h1000_0000);
    rd_chk("R3 rd_end", 4'd3, 32'h1000_7FFC);
    rd_chk("R3 wr_start", 4'd4, 32'h2000_0000);
    rd_chk("R3 scratch", 4'd5, 32'h3000_0100);
    check("R3 ports rd", rd_s ^ rd_e, 32'h1000_0000 ^ 32'h1000_7FFC);
    check("R3 port wr", wr_s, 32'h2000_0000);
    check("R3 port scr", scr, 32'h3000_0100);
  endtask

  task automatic t_unmapped();
    wr(4'd7, 32'hFFFF_FFFF);
    check("R4 ack", {31'b0, c_ack}, 32'h1);
    wr(4'd14, 32'hFFFF_FFFF);
    check("R4 ack14", {31'b0, c_ack}, 32'h1);
    rd_chk("R4 read7", 4'd7, 32'h0);
    rd_chk("R4 read14", 4'd14, 32'h0);
    rd_chk("R4 others kept", 4'd2, 32'h1000_0000);
    rd_chk("R4 status kept", 4'd0, 32'h0);
  endtask

  task automatic t_idle_events();
    wr(4'd1, 32'h0000_0300);
    engine(1'b1, 1'b1);
    header(32'hDEAD_BEEF);
    rd_chk("R14 status", 4'd0, 32'h0);
    rd_chk("R14 header", 4'd6, 32'h0);
    check("R14 irq/hold", {30'b0, irq, hold}, 32'h0);
    rd_chk("R11 mask read", 4'd1, 32'h0000_0300);
  endtask

  task automatic t_start();
    wr(4'd0, 32'h0000_0002);
    check("R5 start pulse", {31'b0, c_start}, 32'h1);
    rd_chk("R5 busy", 4'd0, 32'h0000_0004);
    check("R5 pulse one cycle", {31'b0, p_start}, 32'h0);
    wr(4'd0, 32'h0000_0002);
    check("R5 no pulse while busy", {31'b0, c_start}, 32'h0);
  endtask

  task automatic t_frame();
    wr(4'd1, 32'h0000_0200);
    engine(1'b0, 1'b1);
    check("R7 hold", {31'b0, hold}, 32'h1);
    check("R11 irq wr", {31'b0, irq}, 32'h1);
    rd_chk("R7 flag", 4'd0, 32'h0000_0204);
    wr(4'd4, 32'h2100_0000);
    check("R10 new wr_start", wr_s, 32'h2100_0000);
    check("R10 still held", {31'b0, hold}, 32'h1);
    wr(4'd0, 32'h0000_0000);
    check("R7 write0 no resume", {31'b0, c_wres}, 32'h0);
    rd_chk("R7 write0 keeps flag", 4'd0, 32'h0000_0204);
    wr(4'd0, 32'h0000_0200);
    check("R7 resume", {31'b0, c_wres}, 32'h1);
    rd_chk("R7 cleared", 4'd0, 32'h0000_0004);
    check("R7 hold/irq low", {30'b0, irq, hold}, 32'h0);
  endtask

  task automatic t_input();
    wr(4'd1, 32'h0000_0000);
    engine(1'b1, 1'b0);
    rd_chk("R8 flag", 4'd0, 32'h0000_0104);
    check("R11 masked", {30'b0, irq, hold}, 32'h1);
    wr(4'd2, 32'h4000_0000);
    wr(4'd3, 32'h4000_1000);
    check("R10 rd_start", rd_s, 32'h4000_0000);
    check("R10 rd_end", rd_e, 32'h4000_1000);
    wr(4'd1, 32'h0000_0100);
    check("R11 unmasked", {31'b0, irq}, 32'h1);
    wr(4'd0, 32'h0000_0100);
    check("R8 resume", {31'b0, c_rres}, 32'h1);
    rd_chk("R8 cleared", 4'd0, 32'h0000_0004);
  endtask

  task automatic t_collide();
    engine(1'b0, 1'b1);
    bus(1'b1, 4'd0, 32'h0000_0200, 1'b0, 1'b1);
    check("R9 no resume", {31'b0, c_wres}, 32'h0);
    rd_chk("R9 flag kept", 4'd0, 32'h0000_0204);
    engine(1'b1, 1'b0);
    bus(1'b1, 4'd0, 32'h0000_0100, 1'b1, 1'b0);
    check("R9 rd no resume", {31'b0, c_rres}, 32'h0);
    rd_chk("R9 rd kept", 4'd0, 32'h0000_0304);
    wr(4'd0, 32'h0000_0300);
    check("R9 both resume", {30'b0, c_rres, c_wres}, 32'h3);
  endtask

  task automatic t_header();
    header(32'hA5A5_1234);
    rd_chk("R12 load", 4'd6, 32'hA5A5_1234);
    wr(4'd6, 32'h0);
    rd_chk("R12 host write ignored", 4'd6, 32'hA5A5_1234);
  endtask

  task automatic t_version();
    wr(4'd15, 32'h8000_FFFF);
    rd_chk("R13 version", 4'd15, 32'h8000_0103);
    check("R13 le port", {31'b0, le}, 32'h1);
  endtask

  task automatic t_soft_reset();
    engine(1'b0, 1'b1);
    wr(4'd0, 32'h0000_0003);
    check("R6 reset pulse", {31'b0, c_reset}, 32'h1);
    check("R6 reset beats start", {31'b0, c_start}, 32'h0);
    rd_chk("R6 status", 4'd0, 32'h0);
    rd_chk("R6 header", 4'd6, 32'h0);
    rd_chk("R6 addr kept", 4'd4, 32'h2100_0000);
    rd_chk("R6 mask kept", 4'd1, 32'h0000_0100);
    check("R6 le/hold/irq", {29'b0, le, hold, irq}, 32'h4);
    wr(4'd0, 32'h0000_0002);
    check("R6 restart", {31'b0, c_start}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset_state();
    t_addr();
    t_unmapped();
    t_idle_events();
    t_start();
    t_frame();
    t_input();
    t_collide();
    t_header();
    t_version();
    t_soft_reset();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule